// File: doc/BRIEF.md
# I2C Controller Control Register

This block holds the control word of an I2C controller. The word carries the controller enable, the master/slave role, the transfer direction, the start and stop requests, the acknowledge level and a controller-reset request. Software reaches it through a single-cycle write port. The bit engine reads the stored bits from the outputs. Two kinds of rule apply to a write. Some fields are locked while the bus is busy or while the controller-reset bit is held. Other fields are overridden by hardware events that the bit engine reports.

Every clock cycle the next value is built in three steps. First, the software write is gated by the lockout rules. Second, the hardware events are merged on top of that result, so they win over a write in the same cycle. Third, the combined value is legalised so that the stored word never holds a forbidden combination. A reset or an illegal request therefore never leaves the engine with a start or stop request that it must not act on.

Top module: `i2c_ctl_reg`

## Requirements
- R1: On reset the whole control word reads 0000h.
- R2: A write updates the enable bit (bit 0) when the bus is idle, or when the controller-reset bit is 1. When the bus is busy and controller-reset is 0, the enable bit keeps its value.
- R3: A write to the master-mode bit (bit 1, 1 = master) has no effect while the bus is busy.
- R4: A write to the direction bit (bit 2) takes effect only when the bus is idle and the stored master-mode bit is 1. In master mode, direction 1 means the master receives and 0 means it transmits.
- R5: A slave address match, an arbitration loss or a general-call pulse clears the master-mode bit on the next edge. This holds even when a write in the same cycle sets it.
- R6: A received-R/W strobe loads the direction bit from the received R/W value when the resulting master-mode bit is 0. The strobe wins over a same-cycle write.
- R7: The start bit (bit 3) and the stop bit (bit 4) are 0 whenever enable or master-mode is 0.
- R8: A write with start and stop both 1 leaves both bits unchanged. Any other write loads them as written. Start and stop are never both 1.
- R9: The controller-reset bit (bit 6) is loaded by every write. It is 0 whenever enable is 0.
- R10: A write to the acknowledge bit (bit 5) has no effect while the stored controller-reset bit is 1.
- R11: Bits 15 down to 7 read 0, and writing ones to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Software write strobe, one cycle |
| wr_data | input | 16 | Value being written |
| bus_busy | input | 1 | Bus activity status from the bit engine |
| evt_addr_match | input | 1 | Pulse: own slave address matched |
| evt_arb_lost | input | 1 | Pulse: arbitration lost |
| evt_gen_call | input | 1 | Pulse: general call received |
| rw_strobe | input | 1 | Pulse: R/W bit of the address phase is valid |
| rw_bit | input | 1 | Received R/W bit |
| ctl_q | output | 16 | Stored control word |
| en_o | output | 1 | Controller enable |
| mst_o | output | 1 | Master mode |
| dir_o | output | 1 | Transfer direction |
| start_o | output | 1 | Start request |
| stop_o | output | 1 | Stop request |
| ack_o | output | 1 | Acknowledge level |
| crst_o | output | 1 | Controller-reset request |

## Verification
The assertions assume that the event pulses and the R/W strobe are single-cycle inputs that may arrive in any combination with a write. They also assume that the busy status is sampled on the same edge as the write. No ordering between these inputs is taken for granted. The stimulus holds every input steady from one falling edge to the next. It walks a bijective scramble over all 16384 combinations of write strobe, busy, the three events, the strobe, the received bit and the seven defined data bits. The reserved data bits are toggled alongside. Because the stored state carries from one step to the next, locked and unlocked states are both reached many times.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

   localparam int unsigned FIELD_W   = 7;
   localparam int unsigned POS_EN    = 0;
   localparam int unsigned POS_MST   = 1;
   localparam int unsigned POS_DIR   = 2;
   localparam int unsigned POS_START = 3;
   localparam int unsigned POS_STOP  = 4;
   localparam int unsigned POS_ACK   = 5;
   localparam int unsigned POS_CRST  = 6;

   typedef struct packed {
      logic crst;
      logic ack;
      logic stop;
      logic start;
      logic dir;
      logic mst;
      logic en;
   } ctl_fields_t;

endpackage

// File: rtl/i2c_ctl_sw_gate.sv
module i2c_ctl_sw_gate
   import i2c_ctl_pkg::*;
(
   input  ctl_fields_t cur,
   input  logic        wr_en,
   input  ctl_fields_t wr_val,
   input  logic        bus_busy,
   output ctl_fields_t nxt
);

   logic both_req;
   assign both_req = wr_val.start & wr_val.stop;

   always_comb begin
      nxt = cur;
      if (wr_en) begin
         if (!bus_busy || cur.crst) nxt.en  = wr_val.en;
         if (!bus_busy)             nxt.mst = wr_val.mst;
         if (!bus_busy && cur.mst)  nxt.dir = wr_val.dir;
         if (!both_req) begin
            nxt.start = wr_val.start;
            nxt.stop  = wr_val.stop;
         end
         if (!cur.crst)             nxt.ack = wr_val.ack;
         nxt.crst = wr_val.crst;
      end
   end

endmodule

// File: rtl/i2c_ctl_hw_merge.sv
module i2c_ctl_hw_merge
   import i2c_ctl_pkg::*;
#(
   parameter int unsigned N_EVT = 3
)(
   input  ctl_fields_t      sw_val,
   input  logic [N_EVT-1:0] evt,
   input  logic             rw_strobe,
   input  logic             rw_bit,
   output ctl_fields_t      nxt
);

   logic any_evt;
   assign any_evt = |evt;

   always_comb begin
      nxt = sw_val;
      if (any_evt) nxt.mst = 1'b0;
      if (rw_strobe && !nxt.mst) nxt.dir = rw_bit;
   end

endmodule

// File: rtl/i2c_ctl_legalize.sv
module i2c_ctl_legalize
   import i2c_ctl_pkg::*;
(
   input  ctl_fields_t raw,
   output ctl_fields_t legal
);

   always_comb begin
      legal = raw;
      if (!raw.en || !raw.mst) begin
         legal.start = 1'b0;
         legal.stop  = 1'b0;
      end
      if (!raw.en) legal.crst = 1'b0;
   end

endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
   import i2c_ctl_pkg::*;
#(
   parameter int unsigned REG_W    = 16,
   parameter bit          SYNC_RST = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             bus_busy,
   input  logic             evt_addr_match,
   input  logic             evt_arb_lost,
   input  logic             evt_gen_call,
   input  logic             rw_strobe,
   input  logic             rw_bit,
   output logic [REG_W-1:0] ctl_q,
   output logic             en_o,
   output logic             mst_o,
   output logic             dir_o,
   output logic             start_o,
   output logic             stop_o,
   output logic             ack_o,
   output logic             crst_o
);

   localparam int unsigned N_EVT = 3;

   if (REG_W < FIELD_W) begin : g_bad_width
      $error("i2c_ctl_reg: REG_W must hold all control fields");
   end

   ctl_fields_t cur_q, wr_val, sw_nxt, hw_nxt, legal_nxt;
   logic [N_EVT-1:0] evt_vec;
   logic             unused_wr_bits;

   assign evt_vec        = {evt_gen_call, evt_arb_lost, evt_addr_match};
   assign unused_wr_bits = ^wr_data;

   always_comb begin
      wr_val       = '0;
      wr_val.en    = wr_data[POS_EN];
      wr_val.mst   = wr_data[POS_MST];
      wr_val.dir   = wr_data[POS_DIR];
      wr_val.start = wr_data[POS_START];
      wr_val.stop  = wr_data[POS_STOP];
      wr_val.ack   = wr_data[POS_ACK];
      wr_val.crst  = wr_data[POS_CRST];
   end

   i2c_ctl_sw_gate u_gate (
      .cur      (cur_q),
      .wr_en    (wr_en),
      .wr_val   (wr_val),
      .bus_busy (bus_busy),
      .nxt      (sw_nxt)
   );

   i2c_ctl_hw_merge #(.N_EVT(N_EVT)) u_hw (
      .sw_val    (sw_nxt),
      .evt       (evt_vec),
      .rw_strobe (rw_strobe),
      .rw_bit    (rw_bit),
      .nxt       (hw_nxt)
   );

   i2c_ctl_legalize u_legal (
      .raw   (hw_nxt),
      .legal (legal_nxt)
   );

   if (SYNC_RST) begin : g_sync_rst
      always_ff @(posedge clk) begin
         if (!rst_n) cur_q <= '0;
         else        cur_q <= legal_nxt;
      end
   end else begin : g_async_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cur_q <= '0;
         else        cur_q <= legal_nxt;
      end
   end

   always_comb begin
      ctl_q            = '0;
      ctl_q[POS_EN]    = cur_q.en;
      ctl_q[POS_MST]   = cur_q.mst;
      ctl_q[POS_DIR]   = cur_q.dir;
      ctl_q[POS_START] = cur_q.start;
      ctl_q[POS_STOP]  = cur_q.stop;
      ctl_q[POS_ACK]   = cur_q.ack;
      ctl_q[POS_CRST]  = cur_q.crst;
   end

   assign en_o    = cur_q.en;
   assign mst_o   = cur_q.mst;
   assign dir_o   = cur_q.dir;
   assign start_o = cur_q.start;
   assign stop_o  = cur_q.stop;
   assign ack_o   = cur_q.ack;
   assign crst_o  = cur_q.crst;

   a_r3_busy_keeps_master: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_busy && !(|evt_vec)) |=> $stable(mst_o));

   a_r5_event_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_vec) |=> !mst_o);

   a_r6_slave_takes_rw: assert property (@(posedge clk) disable iff (!rst_n)
      (rw_strobe && (|evt_vec)) |=> (dir_o == $past(rw_bit)));

   a_r7_requests_need_master: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_o && mst_o) |-> !(start_o || stop_o));

   a_r8_single_request: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && stop_o));

   a_r9_crst_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !en_o |-> !crst_o);

   a_r10_ack_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && crst_o) |=> $stable(ack_o));

endmodule

// File: tb/tb_i2c_ctl_reg.sv
`timescale 1ns/1ps
module tb_i2c_ctl_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        bus_busy = 1'b0;
   logic        evt_addr_match = 1'b0, evt_arb_lost = 1'b0, evt_gen_call = 1'b0;
   logic        rw_strobe = 1'b0, rw_bit = 1'b0;
   logic [15:0] ctl_q;
   logic        en_o, mst_o, dir_o, start_o, stop_o, ack_o, crst_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // expected state, bits: 0 en,1 mst,2 dir,3 start,4 stop,5 ack,6 crst
   logic [15:0] model = '0;

   always #2 clk = ~clk;

   i2c_ctl_reg dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .bus_busy(bus_busy), .evt_addr_match(evt_addr_match),
      .evt_arb_lost(evt_arb_lost), .evt_gen_call(evt_gen_call),
      .rw_strobe(rw_strobe), .rw_bit(rw_bit), .ctl_q(ctl_q),
      .en_o(en_o), .mst_o(mst_o), .dir_o(dir_o), .start_o(start_o),
      .stop_o(stop_o), .ack_o(ack_o), .crst_o(crst_o)
   );

   function automatic logic [15:0] predict(input logic [15:0] s, input logic w,
      input logic [15:0] d, input logic busy, input logic [2:0] ev,
      input logic rv, input logic rb);
      logic en, m, dr, st, sp, ak, cr;
      en = s[0]; m = s[1]; dr = s[2]; st = s[3]; sp = s[4]; ak = s[5]; cr = s[6];
      if (w) begin
         if (!busy || s[6]) en = d[0];
         if (!busy) m = d[1];
         if (!busy && s[1]) dr = d[2];
         if (!(d[3] && d[4])) begin st = d[3]; sp = d[4]; end
         if (!s[6]) ak = d[5];
         cr = d[6];
      end
      if (ev != 3'b000) m = 1'b0;
      if (rv && !m) dr = rb;
      if (!en || !m) begin st = 1'b0; sp = 1'b0; end
      if (!en) cr = 1'b0;
      return {9'd0, cr, ak, sp, st, dr, m, en};
   endfunction

   task automatic compare(input string tag, input logic [15:0] exp);
      checks++;
      if (ctl_q !== exp) begin
         errors++;
         $display("FAIL %s: ctl_q=%h expected %h", tag, ctl_q, exp);
      end
   endtask

   task automatic step(input string tag, input logic w, input logic [15:0] d,
      input logic busy, input logic [2:0] ev, input logic rv, input logic rb);
      @(negedge clk);
      wr_en = w; wr_data = d; bus_busy = busy;
      {evt_gen_call, evt_arb_lost, evt_addr_match} = ev;
      rw_strobe = rv; rw_bit = rb;
      model = predict(model, w, d, busy, ev, rv, rb);
      @(posedge clk);
      #1;
      compare(tag, model);
   endtask

   initial begin
      #(4 * 60000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, got %0d expected completion", checks);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 reset value", 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release", 16'h0000);

      step("R2 enable while idle",          1, 16'h0001, 0, 3'b000, 0, 0);
      step("R3 master write while busy",    1, 16'h0003, 1, 3'b000, 0, 0);
      step("R3 master write while idle",    1, 16'h0003, 0, 3'b000, 0, 0);
      step("R4 direction as master",        1, 16'h0007, 0, 3'b000, 0, 0);
      step("R8 start request",              1, 16'h000F, 0, 3'b000, 0, 0);
      step("R8 start and stop together",    1, 16'h001F, 0, 3'b000, 0, 0);
      step("R8 stop request",               1, 16'h0017, 0, 3'b000, 0, 0);
      step("R5 R7 arbitration loss",        1, 16'h000F, 0, 3'b010, 0, 0);
      step("R4 direction write as slave",   1, 16'h0003, 0, 3'b000, 0, 0);
      step("R6 received rw over write",     1, 16'h0005, 0, 3'b000, 1, 0);
      step("R6 received rw one",            0, 16'h0000, 0, 3'b001, 1, 1);
      step("R9 controller reset set",       1, 16'h0041, 0, 3'b000, 0, 0);
      step("R2 R9 R10 busy with crst",      1, 16'h0060, 1, 3'b000, 0, 0);
      step("R10 ack while crst clear",      1, 16'h0021, 0, 3'b000, 0, 0);
      step("R2 enable locked while busy",   1, 16'h0000, 1, 3'b000, 0, 0);
      step("R11 reserved bits",             1, 16'hFF81, 0, 3'b000, 0, 0);
      step("R5 general call",               1, 16'h0003, 0, 3'b100, 0, 0);

      for (int i = 0; i < 16384; i++) begin
         logic [13:0] v;
         v = 14'((i * 7919) & 16383);
         step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 sweep", v[7],
              {{9{v[13]}}, v[6:0]}, v[8], v[11:9], v[12], v[13]);
      end

      @(negedge clk);
      rst_n = 1'b0;
      #1;
      compare("R1 reset mid run", 16'h0000);
      model = '0;
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule